// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block produces the strobe pattern of an 8-bit controller's external memory bus. The low data port carries both the low address byte and data. The bus is run from the oscillator clock in machine cycles of twelve periods, each split into two six-period slots. At the last period of every machine cycle the block samples a request for the next cycle. A request is a cycle kind, an address, write data, the data addressing width, an external-code flag, a table-read flag, the software latch-enable mask and the high-port latch value. It is sampled together with a power mode. The block then drives the address latch strobe, the code read strobe, the data read and write strobes, the low port (value and drive enable) and the high port for the whole cycle. It also captures read bytes from the low port input.

The controller has six states. FETCH emits two latch pulses and, for external code, two code read strobes. DREAD and DWRITE emit one latch pulse and one long data strobe, and the other latch pulse and both code strobes are left out. IDLE holds the latch and code strobes high. PDOWN holds both low. EMU releases every driver. The only transitions happen at the machine-cycle boundary. The run mode picks FETCH, DREAD or DWRITE by cycle kind, and the idle, power-down and emulation modes pick IDLE, PDOWN or EMU, from any state. Reset enters IDLE at the last period of a cycle, so the first request is taken on the first clock edge after reset.

Top module: `xbus_seq`

## Requirements
- R1: A machine cycle lasts 12 clock periods, numbered 0 to 11. `cyc_take` is high only in period 11, and every request input and `pwr_mode` is sampled at the clock edge that ends that period.
- R2: In a FETCH cycle `ale` is high in periods 0-1 and 6-7 and low otherwise, driven (`ale_oe`=1).
- R3: In a data cycle (`req_kind`=1 read, 2 write) `ale` is high only in periods 0-1, and `psen_n` stays high throughout.
- R4: In a FETCH cycle with `ext_code`=1, `psen_n` is low in periods 3-5 and 9-11. With `ext_code`=0 it stays high.
- R5: A read cycle drives `rd_n` low in periods 5-10 only, and a write cycle does the same with `wr_n`. The other strobe stays high.
- R6: The low port drives the low address byte in periods 1-2 of each slot that uses it. A write cycle drives the write data in periods 3-11. At all other times `lo_oe`=0. In FETCH the second slot uses the address plus one.
- R7: The high port shows the address high byte during an external FETCH (from address plus one in the second slot) and during a data cycle with `req_wide`=1. Otherwise it shows `hi_latch`.
- R8: `rd_data` takes `lo_in` at the clock edge that ends the last low period of `rd_n`, or of `psen_n` in an external FETCH. `rd_valid` is high for exactly the following period.
- R9: A FETCH cycle with `ale_dis`=1, `ext_code`=0 and `movc_op`=0 holds `ale`=1 with `ale_oe`=0. In data cycles, or with `ext_code`=1 or `movc_op`=1, `ale_dis` has no effect.
- R10: In IDLE (`pwr_mode`=1) `ale` and `psen_n` stay high, `rd_n` and `wr_n` stay high, and `lo_oe`=0. The high port keeps the address high byte of the last run cycle if that cycle had `ext_code`=1, and the latch value otherwise.
- R11: In PDOWN (`pwr_mode`=2) `ale` and `psen_n` are driven low, and the high port shows the last latched `hi_latch`.
- R12: In EMU (`pwr_mode`=3) `ale_oe`, `psen_oe`, `lo_oe` and `hi_oe` are all 0, with `ale` and `psen_n` at 1.
- R13: While `rst_n` is low the block is in IDLE at period 11: `cyc_take`=1, all strobes high, `lo_oe`=0, high port 0, `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| req_kind | input | 2 | Next cycle kind: 0 fetch, 1 data read, 2 data write |
| req_addr | input | 16 | Address for the next cycle |
| req_wdata | input | 8 | Write data for a write cycle |
| req_wide | input | 1 | 1: data cycle uses a 16-bit address |
| ext_code | input | 1 | Code executes from external memory |
| movc_op | input | 1 | A table read from code memory is in progress |
| ale_dis | input | 1 | Software mask that silences the address latch strobe |
| hi_latch | input | 8 | High-port latch contents |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 power-down, 3 emulation |
| lo_in | input | 8 | Low port input for read capture |
| cyc_take | output | 1 | Last period of the machine cycle; request sampled at its end |
| ale | output | 1 | Address latch strobe, active high |
| ale_oe | output | 1 | Strong drive of the latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| psen_oe | output | 1 | Strong drive of the code read strobe |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_oe | output | 1 | Low port drive enable |
| lo_out | output | 8 | Low port drive value |
| hi_oe | output | 1 | High port drive enable |
| hi_out | output | 8 | High port value |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-period flag for a new capture |

## Verification
On every cycle the assertions check the strobe edges: the latch strobe always falls two periods into a slot, and the data strobes fall at period 5 and rise after period 10. They also check that the low port is never driven while a read or code strobe is low, that no two strobes are low together, and that a capture flag never lasts two periods. Other properties can only be shown by running stimulus: which pulses a given cycle kind leaves out, the exact address, data and high-port values, the interaction of the latch mask with external execution and table reads, and what the high port holds across idle and power-down. The bench covers these by comparing every output in every period against a model of the requirements. It uses a seeded random mix of cycles and modes, plus directed corners such as address carry and wrap into the second fetch slot.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Slot geometry; every strobe position derives from these.
    localparam int unsigned SLOT_LEN    = 6;
    localparam int unsigned SLOTS       = 2;
    localparam int unsigned CYC_LEN     = SLOT_LEN * SLOTS;
    localparam int unsigned ALE_LEN     = 2;
    localparam int unsigned ADDR_FIRST  = ALE_LEN - 1;
    localparam int unsigned ADDR_LAST   = ALE_LEN;
    localparam int unsigned PSEN_FIRST  = ALE_LEN + 1;
    localparam int unsigned PSEN_LAST   = SLOT_LEN - 1;
    localparam int unsigned WDATA_FIRST = ADDR_LAST + 1;
    localparam int unsigned STB_FIRST   = ALE_LEN + 3;
    localparam int unsigned STB_LEN     = 6;
    localparam int unsigned STB_LAST    = STB_FIRST + STB_LEN - 1;

    localparam int unsigned PH_W   = $clog2(CYC_LEN);
    localparam int unsigned SPH_W  = $clog2(SLOT_LEN);
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;

    localparam logic [1:0] MODE_RUN   = 2'd0;
    localparam logic [1:0] MODE_IDLE  = 2'd1;
    localparam logic [1:0] MODE_PDOWN = 2'd2;
    localparam logic [1:0] MODE_EMU   = 2'd3;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DREAD,
        ST_DWRITE,
        ST_IDLE,
        ST_PDOWN,
        ST_EMU
    } xbus_state_e;

endpackage

// File: rtl/xbus_timer.sv
module xbus_timer
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [PH_W-1:0]   ph,
    output logic [SPH_W-1:0]  sph,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);

    localparam logic [PH_W-1:0]   PH_END   = PH_W'(CYC_LEN - 1);
    localparam logic [SPH_W-1:0]  SPH_END  = SPH_W'(SLOT_LEN - 1);
    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOTS - 1);

    assign last = (ph == PH_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= PH_END;
            sph  <= SPH_END;
            slot <= SLOT_END;
        end else begin
            ph <= last ? '0 : ph + 1'b1;
            if (sph == SPH_END) begin
                sph  <= '0;
                slot <= (slot == SLOT_END) ? '0 : slot + 1'b1;
            end else begin
                sph <= sph + 1'b1;
            end
        end
    end

    // R1: the cycle wraps right after the take period
    p_take_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (ph == '0));

    // R1: the slot counters stay aligned to the cycle counter
    p_slot_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == '0) |-> (sph == '0 && slot == '0));

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     last,
    input  logic [1:0]               req_kind,
    input  logic [1:0]               pwr_mode,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_wide,
    input  logic                     ext_code,
    input  logic                     movc_op,
    input  logic                     ale_dis,
    input  logic [ADDR_W-DATA_W-1:0] hi_latch,
    output xbus_state_e              st,
    output logic [ADDR_W-1:0]        addr_q,
    output logic [DATA_W-1:0]        wdata_q,
    output logic                     wide_q,
    output logic                     ext_q,
    output logic                     movc_q,
    output logic                     dis_q,
    output logic [ADDR_W-DATA_W-1:0] latch_q
);

    xbus_state_e st_nx;

    always_comb begin
        st_nx = ST_FETCH;
        unique case (pwr_mode)
            MODE_RUN: begin
                case (req_kind)
                    KIND_READ:  st_nx = ST_DREAD;
                    KIND_WRITE: st_nx = ST_DWRITE;
                    default:    st_nx = ST_FETCH;
                endcase
            end
            MODE_IDLE:  st_nx = ST_IDLE;
            MODE_PDOWN: st_nx = ST_PDOWN;
            MODE_EMU:   st_nx = ST_EMU;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else if (last) begin
            st <= st_nx;
        end
    end

    // Request fields are held across idle and power-down cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
            ext_q   <= 1'b0;
            movc_q  <= 1'b0;
            dis_q   <= 1'b0;
            latch_q <= '0;
        end else if (last && pwr_mode == MODE_RUN) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wide_q  <= req_wide;
            ext_q   <= ext_code;
            movc_q  <= movc_op;
            dis_q   <= ale_dis;
            latch_q <= hi_latch;
        end
    end

    // R1: the state only moves at a cycle boundary
    p_state_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(st));

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  xbus_state_e              st,
    input  logic [PH_W-1:0]          ph,
    input  logic [SPH_W-1:0]         sph,
    input  logic [SLOT_W-1:0]        slot,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic                     wide_q,
    input  logic                     ext_q,
    input  logic                     movc_q,
    input  logic                     dis_q,
    input  logic [ADDR_W-DATA_W-1:0] latch_q,
    input  logic [DATA_W-1:0]        lo_in,
    output logic                     ale,
    output logic                     ale_oe,
    output logic                     psen_n,
    output logic                     psen_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     lo_oe,
    output logic [DATA_W-1:0]        lo_out,
    output logic                     hi_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);

    localparam logic [SPH_W-1:0] S_ALE = SPH_W'(ALE_LEN);
    localparam logic [SPH_W-1:0] S_AF  = SPH_W'(ADDR_FIRST);
    localparam logic [SPH_W-1:0] S_AL  = SPH_W'(ADDR_LAST);
    localparam logic [SPH_W-1:0] S_PF  = SPH_W'(PSEN_FIRST);
    localparam logic [SPH_W-1:0] S_PL  = SPH_W'(PSEN_LAST);
    localparam logic [PH_W-1:0]  P_ALE = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0]  P_AF  = PH_W'(ADDR_FIRST);
    localparam logic [PH_W-1:0]  P_AL  = PH_W'(ADDR_LAST);
    localparam logic [PH_W-1:0]  P_WF  = PH_W'(WDATA_FIRST);
    localparam logic [PH_W-1:0]  P_SF  = PH_W'(STB_FIRST);
    localparam logic [PH_W-1:0]  P_SL  = PH_W'(STB_LAST);
    localparam logic [PH_W-1:0]  P_END = PH_W'(CYC_LEN - 1);

    logic [ADDR_W-1:0] fetch_addr;
    logic              cap;
    logic              in_addr_win;
    logic              in_stb_win;

    assign fetch_addr  = addr_q + ADDR_W'(slot);
    assign in_addr_win = (ph >= P_AF) && (ph <= P_AL);
    assign in_stb_win  = (ph >= P_SF) && (ph <= P_SL);

    always_comb begin
        ale     = 1'b0;
        ale_oe  = 1'b1;
        psen_n  = 1'b1;
        psen_oe = 1'b1;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        lo_oe   = 1'b0;
        lo_out  = '0;
        hi_oe   = 1'b1;
        hi_out  = latch_q;
        cap     = 1'b0;
        unique case (st)
            ST_FETCH: begin
                ale = (sph < S_ALE);
                if (dis_q && !ext_q && !movc_q) begin
                    ale    = 1'b1;
                    ale_oe = 1'b0;
                end
                if (ext_q) begin
                    psen_n = !((sph >= S_PF) && (sph <= S_PL));
                    hi_out = fetch_addr[ADDR_W-1:DATA_W];
                    if ((sph >= S_AF) && (sph <= S_AL)) begin
                        lo_oe  = 1'b1;
                        lo_out = fetch_addr[DATA_W-1:0];
                    end
                    cap = (sph == S_PL);
                end
            end
            ST_DREAD, ST_DWRITE: begin
                ale = (ph < P_ALE);
                if (wide_q) hi_out = addr_q[ADDR_W-1:DATA_W];
                if (in_addr_win) begin
                    lo_oe  = 1'b1;
                    lo_out = addr_q[DATA_W-1:0];
                end
                if (st == ST_DREAD) begin
                    rd_n = !in_stb_win;
                    cap  = (ph == P_SL);
                end else begin
                    wr_n = !in_stb_win;
                    if (ph >= P_WF) begin
                        lo_oe  = 1'b1;
                        lo_out = wdata_q;
                    end
                end
            end
            ST_IDLE: begin
                ale = 1'b1;
                if (ext_q) hi_out = addr_q[ADDR_W-1:DATA_W];
            end
            ST_PDOWN: begin
                ale    = 1'b0;
                psen_n = 1'b0;
            end
            ST_EMU: begin
                ale     = 1'b1;
                ale_oe  = 1'b0;
                psen_oe = 1'b0;
                hi_oe   = 1'b0;
                hi_out  = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap;
            if (cap) rd_data <= lo_in;
        end
    end

    // R2: a driven latch strobe always ends two periods into a slot
    p_ale_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale) && ale_oe && st != ST_PDOWN) |-> (sph == S_ALE));

    // R4: the low port is released while a code read is in progress
    p_psen_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !lo_oe);

    // R5: data strobes open at period 5 and close after period 10
    p_rd_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> (ph == P_SF));
    p_rd_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (ph == P_END));
    p_wr_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> (ph == P_SF));
    p_wr_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ph == P_END));

    // R5: never two bus strobes low at once
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (psen_n && (rd_n || wr_n)));

    // R6: the low port floats while a read is accepted
    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);

    // R8: a capture flag lasts a single period
    p_valid_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_wide,
    input  logic                     ext_code,
    input  logic                     movc_op,
    input  logic                     ale_dis,
    input  logic [ADDR_W-DATA_W-1:0] hi_latch,
    input  logic [1:0]               pwr_mode,
    input  logic [DATA_W-1:0]        lo_in,
    output logic                     cyc_take,
    output logic                     ale,
    output logic                     ale_oe,
    output logic                     psen_n,
    output logic                     psen_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     lo_oe,
    output logic [DATA_W-1:0]        lo_out,
    output logic                     hi_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);

    logic [PH_W-1:0]          ph;
    logic [SPH_W-1:0]         sph;
    logic [SLOT_W-1:0]        slot;
    logic                     last;
    xbus_state_e              st;
    logic [ADDR_W-1:0]        addr_q;
    logic [DATA_W-1:0]        wdata_q;
    logic                     wide_q;
    logic                     ext_q;
    logic                     movc_q;
    logic                     dis_q;
    logic [ADDR_W-DATA_W-1:0] latch_q;

    assign cyc_take = last;

    xbus_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .sph   (sph),
        .slot  (slot),
        .last  (last)
    );

    xbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .last      (last),
        .req_kind  (req_kind),
        .pwr_mode  (pwr_mode),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wide  (req_wide),
        .ext_code  (ext_code),
        .movc_op   (movc_op),
        .ale_dis   (ale_dis),
        .hi_latch  (hi_latch),
        .st        (st),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .wide_q    (wide_q),
        .ext_q     (ext_q),
        .movc_q    (movc_q),
        .dis_q     (dis_q),
        .latch_q   (latch_q)
    );

    xbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .ph       (ph),
        .sph      (sph),
        .slot     (slot),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .wide_q   (wide_q),
        .ext_q    (ext_q),
        .movc_q   (movc_q),
        .dis_q    (dis_q),
        .latch_q  (latch_q),
        .lo_in    (lo_in),
        .ale      (ale),
        .ale_oe   (ale_oe),
        .psen_n   (psen_n),
        .psen_oe  (psen_oe),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .lo_oe    (lo_oe),
        .lo_out   (lo_out),
        .hi_oe    (hi_oe),
        .hi_out   (hi_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_wide, ext_code, movc_op, ale_dis;
    logic [7:0]  hi_latch;
    logic [1:0]  pwr_mode;
    logic [7:0]  lo_in;
    logic        cyc_take, ale, ale_oe, psen_n, psen_oe, rd_n, wr_n, lo_oe, hi_oe, rd_valid;
    logic [7:0]  lo_out, hi_out, rd_data;

    xbus_seq u_xbus_seq (
        .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_wide(req_wide), .ext_code(ext_code),
        .movc_op(movc_op), .ale_dis(ale_dis), .hi_latch(hi_latch),
        .pwr_mode(pwr_mode), .lo_in(lo_in), .cyc_take(cyc_take), .ale(ale),
        .ale_oe(ale_oe), .psen_n(psen_n), .psen_oe(psen_oe), .rd_n(rd_n),
        .wr_n(wr_n), .lo_oe(lo_oe), .lo_out(lo_out), .hi_oe(hi_oe),
        .hi_out(hi_out), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int checks = 0;
    int errors = 0;

    // model state: current cycle and fields held from the last run cycle
    logic [1:0]  c_mode = 2'd1;
    logic [1:0]  c_kind = 2'd0;
    logic [15:0] c_addr = 16'h0;
    logic [7:0]  c_wdata = 8'h0;
    logic        c_wide = 1'b0, c_ext = 1'b0, c_movc = 1'b0, c_dis = 1'b0;
    logic [15:0] h_addr = 16'h0;
    logic        h_ext = 1'b0;
    logic [7:0]  h_latch = 8'h0;
    logic        exp_valid = 1'b0;
    logic [7:0]  exp_rdata = 8'h0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check_period(input int p);
        int s;
        logic [15:0] fa;
        logic e_ale, e_ale_oe, e_psen, e_psen_oe, e_rd, e_wr, e_lo_oe, e_hi_oe, cap;
        logic [7:0] e_lo, e_hi;
        string t_ale, t_psen, t_port, t_hi;
        s = p % 6;
        fa = h_addr + 16'(p / 6);
        e_ale = 1'b0; e_ale_oe = 1'b1; e_psen = 1'b1; e_psen_oe = 1'b1;
        e_rd = 1'b1; e_wr = 1'b1; e_lo_oe = 1'b0; e_lo = 8'h0;
        e_hi_oe = 1'b1; e_hi = h_latch;
        t_ale = "R2 ale"; t_psen = "R4 psen"; t_port = "R6 lo"; t_hi = "R7 hi";
        case (c_mode)
            2'd1: begin
                e_ale = 1'b1;
                e_hi = h_ext ? h_addr[15:8] : h_latch;
                t_ale = "R10 ale"; t_psen = "R10 psen"; t_port = "R10 lo"; t_hi = "R10 hi";
            end
            2'd2: begin
                e_ale = 1'b0; e_psen = 1'b0;
                t_ale = "R11 ale"; t_psen = "R11 psen"; t_port = "R11 lo"; t_hi = "R11 hi";
            end
            2'd3: begin
                e_ale = 1'b1; e_ale_oe = 1'b0; e_psen_oe = 1'b0; e_hi_oe = 1'b0;
                t_ale = "R12 ale"; t_psen = "R12 psen"; t_port = "R12 lo"; t_hi = "R12 hi";
            end
            default: begin
                if (c_kind == 2'd1 || c_kind == 2'd2) begin
                    e_ale = (p < 2);
                    t_ale = "R3 ale"; t_psen = "R3 psen";
                    e_hi = c_wide ? c_addr[15:8] : h_latch;
                    if (p >= 1 && p <= 2) begin e_lo_oe = 1'b1; e_lo = c_addr[7:0]; end
                    if (c_kind == 2'd1) e_rd = !(p >= 5 && p <= 10);
                    else begin
                        e_wr = !(p >= 5 && p <= 10);
                        if (p >= 3) begin e_lo_oe = 1'b1; e_lo = c_wdata; end
                    end
                end else begin
                    e_ale = (s < 2);
                    if (c_dis && !c_ext && !c_movc) begin
                        e_ale = 1'b1; e_ale_oe = 1'b0; t_ale = "R9 ale";
                    end
                    if (c_ext) begin
                        e_psen = !(s >= 3);
                        e_hi = fa[15:8];
                        if (s >= 1 && s <= 2) begin e_lo_oe = 1'b1; e_lo = fa[7:0]; end
                    end
                end
            end
        endcase
        chk("R1 take", 16'(cyc_take), 16'(p == 11));
        chk(t_ale, 16'({ale, ale_oe}), 16'({e_ale, e_ale_oe}));
        chk(t_psen, 16'({psen_n, psen_oe}), 16'({e_psen, e_psen_oe}));
        chk("R5 rd_wr", 16'({rd_n, wr_n}), 16'({e_rd, e_wr}));
        chk(t_port, 16'(lo_oe), 16'(e_lo_oe));
        if (e_lo_oe) chk(t_port, 16'(lo_out), 16'(e_lo));
        chk(t_hi, 16'(hi_oe), 16'(e_hi_oe));
        if (e_hi_oe) chk(t_hi, 16'(hi_out), 16'(e_hi));
        chk("R8 valid", 16'(rd_valid), 16'(exp_valid));
        if (exp_valid) chk("R8 data", 16'(rd_data), 16'(exp_rdata));
        // new low port input for the coming edge; predict a capture
        lo_in = 8'($urandom);
        cap = (c_mode == 2'd0) &&
              ((c_kind == 2'd1 && p == 10) ||
               (c_kind != 2'd1 && c_kind != 2'd2 && c_ext && s == 5));
        exp_valid = cap;
        if (cap) exp_rdata = lo_in;
    endtask

    task automatic run_cycle(input logic [1:0] mode, input logic [1:0] kind,
                             input logic [15:0] addr, input logic [7:0] wdata,
                             input logic wide, input logic ext, input logic movc,
                             input logic dis, input logic [7:0] latch);
        pwr_mode = mode; req_kind = kind; req_addr = addr; req_wdata = wdata;
        req_wide = wide; ext_code = ext; movc_op = movc; ale_dis = dis; hi_latch = latch;
        rst_n = 1'b1;
        c_mode = mode; c_kind = kind; c_addr = addr; c_wdata = wdata;
        c_wide = wide; c_ext = ext; c_movc = movc; c_dis = dis;
        if (mode == 2'd0) begin
            h_addr = addr; h_ext = ext; h_latch = latch;
        end
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            check_period(p);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        req_kind = 2'd0; req_addr = 16'h0; req_wdata = 8'h0; req_wide = 1'b0;
        ext_code = 1'b0; movc_op = 1'b0; ale_dis = 1'b0; hi_latch = 8'h0;
        pwr_mode = 2'd0; lo_in = 8'h0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 take", 16'(cyc_take), 16'd1);
        chk("R13 strobes", 16'({ale, ale_oe, psen_n, rd_n, wr_n}), 16'(5'b11111));
        chk("R13 lo_oe", 16'(lo_oe), 16'd0);
        chk("R13 hi", 16'(hi_out), 16'h00);
        chk("R13 valid", 16'(rd_valid), 16'd0);

        // directed corners
        run_cycle(2'd0, 2'd0, 16'h12FF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h33); // R7 carry
        run_cycle(2'd0, 2'd0, 16'hFFFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h33); // R6 wrap
        run_cycle(2'd1, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R10 hold
        run_cycle(2'd0, 2'd0, 16'h4000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5); // R9 active
        run_cycle(2'd0, 2'd0, 16'h4000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5); // R9 table read
        run_cycle(2'd0, 2'd0, 16'h4002, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5); // R9 external
        run_cycle(2'd0, 2'd1, 16'hBEEF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A); // R3 R8
        run_cycle(2'd0, 2'd2, 16'hC0DE, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A); // R5 R7
        run_cycle(2'd1, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R10
        run_cycle(2'd2, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R11
        run_cycle(2'd3, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R12
        run_cycle(2'd0, 2'd1, 16'h0102, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE1); // R8

        // seeded random mix
        for (int n = 0; n < 160; n++) begin
            logic [1:0] m;
            int r;
            r = int'($urandom % 10);
            m = (r == 0) ? 2'd1 : (r == 1) ? 2'd2 : (r == 2) ? 2'd3 : 2'd0;
            run_cycle(m, 2'($urandom % 3), 16'($urandom), 8'($urandom),
                      1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                      ($urandom % 3) == 0, 8'($urandom));
        end

        report();
        $finish;
    end

endmodule